// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block sits behind a two-register window on a byte-wide host bus: one port takes a register index, the other carries the data of the indexed register. After reset the window is closed. A host opens it by writing a fixed four-byte key to the index port. The last byte of that key depends on which of two base ports the window is decoded at. Once open, the host selects a register by writing its index to the index port and then reads or writes the data port.

The register file behind the window holds a read-only 16-bit chip identifier split over two indices, a read-only revision nibble, a logical-device select register and, for each logical device, a 16-bit base address reachable as a high and a low byte through the select register. All base addresses leave the block on a flat bus for the device decoders elsewhere in the chip. A write of a value with bit 1 set to the control index closes the window again. Chip identifier, revision, device count and reset base addresses are parameters.

The data port is read without side effects: `host_rdata` always shows the data-port view of the current index.

Top module: `cfgport_unlock`

## Requirements
- R1: After reset the window is closed (`cfg_open` low), the key matcher is at its start, the index is 0x00, the device select is 0x00 and `host_rdata` reads 0xFF.
- R2: While closed, index-port writes of 0x87, 0x01, 0x55 and then a fourth byte open the window in the cycle after the fourth write; the fourth byte is 0x55 when `alt_port` is 0 and 0xAA when `alt_port` is 1, and the other value does not open it.
- R3: While closed, an index-port write that is not the next expected key byte returns the matcher to its start, except that 0x87 places it after the first key byte (so 0x87, 0x87, 0x01, 0x55, key4 opens the window).
- R4: While closed, `host_rdata` reads 0xFF and data-port writes change no register and no base address.
- R5: While open, an index-port write stores the index; `host_rdata` then shows the register at that index, and indices with no register (including 0x02) read 0x00.
- R6: Index 0x20 reads the high byte and index 0x21 the low byte of the `CHIP_ID` parameter.
- R7: Index 0x22 reads the low four bits of the `CHIP_REV` parameter with bits 7:4 as zero.
- R8: Index 0x07 is the device select (read/write, 8 bits); indices 0x60 and 0x61 read and write the high and low byte of the selected device's base address; device d drives `dev_base[16*d+15:16*d]`.
- R9: A data-port write to index 0x02 with bit 1 set closes the window and restarts the matcher, so a full key is needed again; values with bit 1 clear have no effect.
- R10: Data-port writes to indices 0x20, 0x21 and 0x22 change nothing.
- R11: Reset loads each device's base address from `DEV_BASE_INIT` (device d at bits 16*d+15:16*d).
- R12: With a device select not below `NUM_DEV`, indices 0x60 and 0x61 read 0x00 and writes to them change no base address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_port | input | 1 | 1 when the window is decoded at the alternate base port |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_sel | input | 1 | Port select: 0 index port, 1 data port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Data-port view of the current index (0xFF while closed) |
| cfg_open | output | 1 | Window open |
| dev_base | output | 16*NUM_DEV | Base addresses of all logical devices, device 0 in the low bits |

## Verification
The bench drives key sequences broken at each step, a repeated 0x87 that must restart rather than abort the matcher, and the fourth byte of the wrong base port; a matcher that clears on 0x87 stays closed where it should open, and one that ignores `alt_port` opens on the wrong key. Data writes while closed and writes to the identifier and revision indices must leave every base address and the device select untouched, which a design that gates only reads would break. A device select beyond the device count must read zeros and protect all bases, and a control write without bit 1 must not close the window; random interleavings of these with relocks compare every cycle against a bench model.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Register indices the host decodes
  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  // Key bytes
  localparam logic [7:0] KEY_B0     = 8'h87;
  localparam logic [7:0] KEY_B1     = 8'h01;
  localparam logic [7:0] KEY_B2     = 8'h55;
  localparam logic [7:0] KEY_B3_PRI = 8'h55;
  localparam logic [7:0] KEY_B3_ALT = 8'hAA;

  localparam logic [7:0] CLOSED_READ = 8'hFF;
  localparam int         CTRL_LOCK_BIT = 1;

  typedef struct packed {
    logic ctrl;
    logic devsel;
    logic id_hi;
    logic id_lo;
    logic rev;
    logic base_hi;
    logic base_lo;
  } cfg_hit_t;

  // Expected byte for a given matcher step
  function automatic logic [7:0] key_byte(input logic [1:0] step, input logic alt);
    case (step)
      2'd0:    key_byte = KEY_B0;
      2'd1:    key_byte = KEY_B1;
      2'd2:    key_byte = KEY_B2;
      default: key_byte = alt ? KEY_B3_ALT : KEY_B3_PRI;
    endcase
  endfunction

  // Revision view: low nibble only
  function automatic logic [7:0] rev_view(input logic [7:0] rev);
    rev_view = {4'h0, rev[3:0]};
  endfunction

endpackage

// File: rtl/cfgport_keymatch.sv
module cfgport_keymatch
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic [7:0] wdata,
  input  logic       alt,
  input  logic       lock_req,
  output logic       open,
  output logic       key_done
);

  logic [1:0] step_q;
  logic       key_hit;
  logic       key_restart;
  logic       key_miss;

  always_comb begin
    key_hit     = addr_wr && !open && (wdata == key_byte(step_q, alt));
    key_done    = key_hit && (step_q == 2'd3);
    key_restart = addr_wr && !open && !key_hit && (wdata == KEY_B0);
    key_miss    = addr_wr && !open && !key_hit && !key_restart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open   <= 1'b0;
      step_q <= 2'd0;
    end else if (lock_req) begin
      open   <= 1'b0;
      step_q <= 2'd0;
    end else if (key_done) begin
      open   <= 1'b1;
      step_q <= 2'd0;
    end else if (key_hit) begin
      step_q <= step_q + 2'd1;
    end else if (key_restart) begin
      step_q <= 2'd1;
    end else if (key_miss) begin
      step_q <= 2'd0;
    end
  end

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> ($past(addr_wr) && $past(step_q) == 2'd3)); // R2

  AST_OPEN_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> (step_q == 2'd0)); // R2

  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !open && wdata != key_byte(step_q, alt) && wdata != KEY_B0)
      |=> (step_q == 2'd0 && !open)); // R3

  AST_RESTART_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !open && step_q != 2'd0 && wdata == KEY_B0 &&
     wdata != key_byte(step_q, alt)) |=> (step_q == 2'd1)); // R3

endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
(
  input  logic [7:0] idx,
  output cfg_hit_t   hit
);

  always_comb begin
    hit         = '0;
    hit.ctrl    = (idx == IDX_CTRL);
    hit.devsel  = (idx == IDX_DEVSEL);
    hit.id_hi   = (idx == IDX_ID_HI);
    hit.id_lo   = (idx == IDX_ID_LO);
    hit.rev     = (idx == IDX_REV);
    hit.base_hi = (idx == IDX_BASE_HI);
    hit.base_lo = (idx == IDX_BASE_LO);
  end

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
  import cfgport_pkg::*;
#(
  parameter int                      NUM_DEV       = 4,
  parameter logic [15:0]             CHIP_ID       = 16'h5A3C,
  parameter logic [7:0]              CHIP_REV      = 8'hB7,
  parameter logic [NUM_DEV*16-1:0]   DEV_BASE_INIT = {NUM_DEV{16'h0000}}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   open,
  input  logic                   data_wr,
  input  logic [7:0]             wdata,
  input  cfg_hit_t               hit,
  output logic [7:0]             view,
  output logic                   lock_req,
  output logic [NUM_DEV*16-1:0]  dev_base
);

  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]  devsel_q;
  logic        dev_ok;
  logic        wr_ok;
  logic [15:0] base_q [NUM_DEV];
  logic [15:0] sel_base;

  assign dev_ok   = (32'(devsel_q) < NUM_DEV);
  assign wr_ok    = data_wr && open;
  assign lock_req = wr_ok && hit.ctrl && wdata[CTRL_LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)                    devsel_q <= 8'h00;
    else if (wr_ok && hit.devsel)  devsel_q <= wdata;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic this_dev;
    assign this_dev = dev_ok && (devsel_q[DEV_W-1:0] == DEV_W'(d));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[d] <= DEV_BASE_INIT[16*d +: 16];
      end else if (wr_ok && this_dev) begin
        if (hit.base_hi) base_q[d][15:8] <= wdata;
        if (hit.base_lo) base_q[d][7:0]  <= wdata;
      end
    end

    assign dev_base[16*d +: 16] = base_q[d];
  end

  assign sel_base = dev_ok ? base_q[devsel_q[DEV_W-1:0]] : 16'h0000;

  always_comb begin
    view = 8'h00;
    if (hit.devsel)       view = devsel_q;
    else if (hit.id_hi)   view = CHIP_ID[15:8];
    else if (hit.id_lo)   view = CHIP_ID[7:0];
    else if (hit.rev)     view = rev_view(CHIP_REV);
    else if (hit.base_hi) view = sel_base[15:8];
    else if (hit.base_lo) view = sel_base[7:0];
  end

  AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && data_wr) |=> ($stable(dev_base) && $stable(devsel_q))); // R4

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (hit.id_hi || hit.id_lo || hit.rev))
      |=> ($stable(dev_base) && $stable(devsel_q))); // R10

  AST_REV_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit.rev |-> (view[7:4] == 4'h0)); // R7

  AST_BAD_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !dev_ok) |=> $stable(dev_base)); // R12

endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter int                      NUM_DEV       = 4,
  parameter logic [15:0]             CHIP_ID       = 16'h5A3C,
  parameter logic [7:0]              CHIP_REV      = 8'hB7,
  parameter logic [NUM_DEV*16-1:0]   DEV_BASE_INIT = {16'h0A40, 16'h0290, 16'h0300, 16'h03F8}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alt_port,
  input  logic                   host_wr,
  input  logic                   host_sel,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic                   cfg_open,
  output logic [NUM_DEV*16-1:0]  dev_base
);

  logic       addr_wr;
  logic       data_wr;
  logic       lock_req;
  logic       key_done;
  logic [7:0] idx_q;
  logic [7:0] view;
  cfg_hit_t   hit;

  assign addr_wr = host_wr && !host_sel;
  assign data_wr = host_wr &&  host_sel;

  cfgport_keymatch u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (addr_wr),
    .wdata    (host_wdata),
    .alt      (alt_port),
    .lock_req (lock_req),
    .open     (cfg_open),
    .key_done (key_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    idx_q <= 8'h00;
    else if (addr_wr && cfg_open)  idx_q <= host_wdata;
  end

  cfgport_decode u_dec (
    .idx (idx_q),
    .hit (hit)
  );

  cfgport_regfile #(
    .NUM_DEV       (NUM_DEV),
    .CHIP_ID       (CHIP_ID),
    .CHIP_REV      (CHIP_REV),
    .DEV_BASE_INIT (DEV_BASE_INIT)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .open     (cfg_open),
    .data_wr  (data_wr),
    .wdata    (host_wdata),
    .hit      (hit),
    .view     (view),
    .lock_req (lock_req),
    .dev_base (dev_base)
  );

  assign host_rdata = cfg_open ? view : CLOSED_READ;

  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> !cfg_open); // R9

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> cfg_open); // R2

  AST_IDX_FROZEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(idx_q)); // R5

endmodule

// File: tb/cfgport_unlock_tb.sv
`timescale 1ns/1ps
module cfgport_unlock_tb;

  localparam int          NUM_DEV = 4;
  localparam logic [15:0] T_ID    = 16'h5A3C;
  localparam logic [7:0]  T_REV   = 8'hB7;
  localparam logic [63:0] T_BASE  = {16'h0A40, 16'h0290, 16'h0300, 16'h03F8};

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  alt_port = 1'b0;
  logic                  host_wr = 1'b0;
  logic                  host_sel = 1'b0;
  logic [7:0]            host_wdata = 8'h00;
  logic [7:0]            host_rdata;
  logic                  cfg_open;
  logic [NUM_DEV*16-1:0] dev_base;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  cfgport_unlock u_dut (
    .clk(clk), .rst_n(rst_n), .alt_port(alt_port), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cfg_open(cfg_open), .dev_base(dev_base)
  );

  // Bench model
  bit          m_open;
  int          m_step;
  logic [7:0]  m_idx;
  logic [7:0]  m_dsel;
  logic [15:0] m_base [NUM_DEV];

  function automatic logic [7:0] m_key(int s, bit alt);
    if (s == 0) return 8'h87;
    if (s == 1) return 8'h01;
    if (s == 2) return 8'h55;
    return alt ? 8'hAA : 8'h55;
  endfunction

  function automatic logic [7:0] m_read();
    logic [15:0] b;
    if (!m_open) return 8'hFF;
    b = (m_dsel < NUM_DEV) ? m_base[m_dsel] : 16'h0000;
    case (m_idx)
      8'h07: return m_dsel;
      8'h20: return T_ID[15:8];
      8'h21: return T_ID[7:0];
      8'h22: return T_REV & 8'h0F;
      8'h60: return b[15:8];
      8'h61: return b[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] m_pack();
    logic [63:0] p;
    for (int d = 0; d < NUM_DEV; d++) p[16*d +: 16] = m_base[d];
    return p;
  endfunction

  task automatic m_reset();
    m_open = 0; m_step = 0; m_idx = 8'h00; m_dsel = 8'h00;
    for (int d = 0; d < NUM_DEV; d++) m_base[d] = T_BASE[16*d +: 16];
  endtask

  task automatic m_addr(logic [7:0] b);
    if (m_open) m_idx = b;
    else if (b == m_key(m_step, alt_port)) begin
      if (m_step == 3) begin m_open = 1; m_step = 0; end
      else m_step++;
    end else if (b == 8'h87) m_step = 1;
    else m_step = 0;
  endtask

  task automatic m_data(logic [7:0] b);
    if (!m_open) return;
    case (m_idx)
      8'h02: if (b[1]) begin m_open = 0; m_step = 0; end
      8'h07: m_dsel = b;
      8'h60: if (m_dsel < NUM_DEV) m_base[m_dsel][15:8] = b;
      8'h61: if (m_dsel < NUM_DEV) m_base[m_dsel][7:0] = b;
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    vectors++;
    if (host_rdata !== m_read()) begin
      miscompares++;
      $display("FAIL %s rdata actual=%02h expected=%02h", tag, host_rdata, m_read());
    end
    vectors++;
    if (cfg_open !== m_open) begin
      miscompares++;
      $display("FAIL %s open actual=%0b expected=%0b", tag, cfg_open, m_open);
    end
    vectors++;
    if (dev_base !== m_pack()) begin
      miscompares++;
      $display("FAIL %s dev_base actual=%016h expected=%016h", tag, dev_base, m_pack());
    end
  endtask

  task automatic wr(bit sel, logic [7:0] b, string tag);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
    if (sel) m_data(b); else m_addr(b);
    check(tag);
  endtask

  task automatic key(bit alt4, string tag);
    wr(0, 8'h87, tag); wr(0, 8'h01, tag); wr(0, 8'h55, tag);
    wr(0, alt4 ? 8'hAA : 8'h55, tag);
  endtask

  task automatic set_alt(bit a, string tag);
    @(negedge clk);
    alt_port = a;
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [7:0] pick_idx(int k);
    case (k % 7)
      0: return 8'h02; 1: return 8'h07; 2: return 8'h20; 3: return 8'h21;
      4: return 8'h22; 5: return 8'h60; default: return 8'h61;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1/R11 reset");

    // Closed: data writes ignored
    wr(1, 8'h5A, "R4 closed data write");
    wr(0, 8'h07, "R3 non-key byte");
    wr(1, 8'h03, "R4 closed data write 2");

    // Broken and wrong keys
    wr(0, 8'h87, "R3"); wr(0, 8'h01, "R3"); wr(0, 8'h55, "R3");
    wr(0, 8'h33, "R3 broken at step 4");
    key(1'b1, "R2 alt byte on primary port");
    wr(0, 8'h87, "R3 restart"); wr(0, 8'h87, "R3 restart repeat");
    wr(0, 8'h01, "R3"); wr(0, 8'h55, "R3"); wr(0, 8'h55, "R3 restart opens");

    // Open: identifier, revision, unmapped
    wr(0, 8'h20, "R6 id high"); wr(0, 8'h21, "R6 id low");
    wr(0, 8'h22, "R7 revision nibble"); wr(0, 8'h33, "R5 unmapped index");
    wr(0, 8'h02, "R5 control reads zero");
    wr(0, 8'h20, "R10"); wr(1, 8'h11, "R10 id write ignored");
    wr(0, 8'h22, "R10"); wr(1, 8'hEE, "R10 rev write ignored");

    // Device select and bases
    wr(0, 8'h07, "R8"); wr(1, 8'h02, "R8 select device 2");
    wr(0, 8'h60, "R8"); wr(1, 8'h12, "R8 base high");
    wr(0, 8'h61, "R8"); wr(1, 8'h34, "R8 base low");
    wr(0, 8'h60, "R8 base readback");
    wr(0, 8'h07, "R12"); wr(1, 8'h09, "R12 select out of range");
    wr(0, 8'h60, "R12 reads zero"); wr(1, 8'h77, "R12 write ignored");
    wr(0, 8'h61, "R12"); wr(1, 8'h78, "R12 write ignored low");

    // Control
    wr(0, 8'h02, "R9"); wr(1, 8'h01, "R9 bit1 clear keeps open");
    wr(1, 8'h02, "R9 relock");
    wr(0, 8'h55, "R9 key restarts"); wr(0, 8'h55, "R9 no stale step");

    // Alternate port
    set_alt(1'b1, "R2 alt select");
    key(1'b0, "R2 primary byte on alt port");
    key(1'b1, "R2 alt key opens");
    wr(0, 8'h02, "R9"); wr(1, 8'hFF, "R9 relock alt");
    set_alt(1'b0, "R2 back to primary");

    // Random phase
    void'($urandom(32'h00C0F1E5));
    for (int n = 0; n < 4000; n++) begin
      int r;
      int k;
      logic [7:0] b;
      r = $urandom % 100;
      k = $urandom % 10;
      if (r < 4) begin
        set_alt(~alt_port, "R2 random alt");
      end else if (r < 55) begin
        case (k)
          0, 6: b = 8'h87;
          1:    b = 8'h01;
          2, 7: b = 8'h55;
          3:    b = 8'hAA;
          4, 8: b = pick_idx($urandom);
          default: b = 8'($urandom);
        endcase
        wr(0, b, "R2/R3/R5 random index write");
      end else begin
        case (k)
          0, 1: b = 8'($urandom % 6);
          2:    b = 8'h02;
          default: b = 8'($urandom);
        endcase
        wr(1, b, "R4/R8/R9/R12 random data write");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule